// File: doc/BRIEF.md
# Serial-Loaded Wiper Code Register

This block is the digital control core of a digitally programmed resistor with 2^CODE_W taps (128 by default). A host writes a tap code over a three-wire serial link: a serial clock, an active-low select and a data line. While the select is low, each rising serial-clock edge shifts one data bit into a shift register. When the select is released, the most recent CODE_W bits become the active wiper code. The shift register's far end drives a serial output, so that several devices can share one data stream in a daisy chain.

All logic runs on one fast system clock. The serial clock, select, data, reset and shutdown pins pass through synchronizers. Edges are detected in the system-clock domain. The reset pin asserts asynchronously and releases synchronously. While it is low it parks the wiper at midscale. The shutdown pin asks the resistor network to open terminal A and tie the wiper to terminal B, and releases the serial output. The stored code is kept through shutdown and serial loading still works. The outputs are the stored code, a one-hot tap select for the resistor switch array, the two shutdown controls and an open-drain pull-down enable for the serial output.

Top module: `wiper_code_ctrl`

## Requirements
- R1: While the select is low, each rising serial-clock edge shifts the data bit into the shift register, most significant bit first. In a CODE_W-bit frame the first bit sent becomes bit CODE_W-1 of the code.
- R2: A rising edge of the select copies the last CODE_W bits shifted into the wiper code. Earlier bits of a longer frame are discarded. A 10-bit frame loads its low 7 bits.
- R3: With the select high, serial-clock edges and data changes leave both the wiper code and the serial output line unchanged.
- R4: Before each shift, the serial output line (high when the pull-down is off) carries the bit entered CODE_W shifts earlier. Two chained devices loaded with one 14-bit frame end with the first 7 bits in the downstream device and the last 7 bits in the upstream device.
- R5: While reset is low, the wiper code is 0x40 and the shift register is cleared, so the pull-down is on when not in shutdown. A reset pulse with the select high leaves 0x40 in place.
- R6: Reset wins over a select-rising transfer that happens in the same system cycle. The code stays 0x40.
- R7: While shutdown is low, terminal-A-open and wiper-to-B are both 1, the serial pull-down is off, and the tap select has only bit 0 set.
- R8: Shutdown does not change the stored wiper code. After release, the tap select again shows the code held before shutdown.
- R9: Frames sent during shutdown update the stored code. The new code drives the tap select after release.
- R10: Outside shutdown, the tap select is one-hot with bit index equal to the code. Code 0x00 sets bit 0, the B contact. Code 0x7F sets bit 127, the top tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock for all logic |
| sclk_i | input | 1 | Serial clock, rising edge shifts |
| csn_i | input | 1 | Active-low serial select |
| sdi_i | input | 1 | Serial data in |
| rstn_i | input | 1 | Active-low reset to midscale |
| shdnn_i | input | 1 | Active-low shutdown |
| wiper_code_o | output | CODE_W | Stored wiper code |
| tap_sel_o | output | 2^CODE_W | One-hot tap switch select |
| a_open_o | output | 1 | Open terminal A |
| w_short_b_o | output | 1 | Tie wiper to terminal B |
| sdo_pulldown_o | output | 1 | Serial output pull-down enable (1 drives the line low) |

## Verification
The bench loads every one of the 128 codes in turn. It checks the code and the one-hot tap bit after each frame. It also checks the serial output before every shift against the previous frame's bits. A design with reversed bit order, an off-by-one output tap or a broken decoder would fail this sweep.

An over-long frame catches a design that keeps the first bits instead of the last. A two-device 14-bit chain catches an output stage that is one shift late or early. Serial-clock activity with the select high catches a missing select gate.

Reset is applied in the middle of a frame, with the select high, and in the same cycle as a select release. A design that lets a transfer beat reset would leave a non-midscale code. The shutdown sequence loads a code while shut down and checks the tap select before and after release. A design that cleared the code, or blocked loading in shutdown, would show the wrong tap on release.

// File: rtl/wcr_pkg.sv
package wcr_pkg;
   // one synchronized control snapshot in the system domain
   typedef struct packed {
      logic sclk;
      logic csn;
      logic sdi;
      logic shdnn;
   } wcr_pins_t;

   localparam int unsigned PIN_CNT = 4;

   // rest values loaded while reset is active: clock low, select high,
   // data low, shutdown inactive
   localparam logic [PIN_CNT-1:0] PIN_IDLE = 4'b0101;

   function automatic logic [15:0] midscale(input int unsigned w);
      return 16'(1) << (w - 1);
   endfunction
endpackage

// File: rtl/wcr_rst_sync.sv
module wcr_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rstn_async_i,
   output logic rstn_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wcr_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rstn_async_i) begin
      if (!rstn_async_i) chain_q <= '0;
      else               chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign rstn_o = chain_q[STAGES-1];
endmodule

// File: rtl/wcr_sync.sv
module wcr_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wcr_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("wcr_sync: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] stg_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) stg_q <= {STAGES{RST_VAL[b]}};
         else         stg_q <= {stg_q[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = stg_q[STAGES-1];
   end
endmodule

// File: rtl/wcr_shift.sv
module wcr_shift #(
   parameter int unsigned CODE_W    = 7,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              shift_i,
   input  logic              sdi_i,
   output logic [CODE_W-1:0] word_o,
   output logic              tail_o
);
   if (CODE_W < 2) begin : g_bad_w
      $error("wcr_shift: CODE_W must be at least 2");
   end

   logic [CODE_W-1:0] sr_q;
   logic [CODE_W-1:0] sr_next;

   if (MSB_FIRST) begin : g_msb
      // newest bit enters at bit 0, oldest leaves from the top
      always_comb sr_next = {sr_q[CODE_W-2:0], sdi_i};
      assign tail_o = sr_q[CODE_W-1];
   end else begin : g_lsb
      always_comb sr_next = {sdi_i, sr_q[CODE_W-1:1]};
      assign tail_o = sr_q[0];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sr_q <= '0;
      else if (shift_i) sr_q <= sr_next;
   end

   assign word_o = sr_q;

   // R3
   sr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !shift_i |=> $stable(sr_q));
endmodule

// File: rtl/wcr_latch.sv
module wcr_latch #(
   parameter int unsigned CODE_W = 7,
   parameter logic [CODE_W-1:0] RST_CODE = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [CODE_W-1:0] din_i,
   output logic [CODE_W-1:0] code_o
);
   logic [CODE_W-1:0] code_q;

   // the async reset wins over any load in the same cycle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     code_q <= RST_CODE;
      else if (load_i) code_q <= din_i;
   end

   assign code_o = code_q;

   // R8
   code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(code_q));
endmodule

// File: rtl/wcr_tap_decode.sv
module wcr_tap_decode #(
   parameter int unsigned CODE_W = 7,
   localparam int unsigned TAPS = 1 << CODE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CODE_W-1:0] code_i,
   input  logic              park_b_i,
   output logic [TAPS-1:0]   tap_o
);
   // tap 0 is the B-terminal contact; parking forces it
   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      if (t == 0) begin : g_b
         assign tap_o[t] = park_b_i || (code_i == CODE_W'(t));
      end else begin : g_up
         assign tap_o[t] = !park_b_i && (code_i == CODE_W'(t));
      end
   end

   // R10
   tap_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot(tap_o));
   // R7
   park_tap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      park_b_i |-> tap_o[0]);
endmodule

// File: rtl/wiper_code_ctrl.sv
module wiper_code_ctrl
   import wcr_pkg::*;
#(
   parameter int unsigned CODE_W      = 7,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          MSB_FIRST   = 1'b1,
   localparam int unsigned TAPS = 1 << CODE_W
) (
   input  logic              clk_i,
   input  logic              sclk_i,
   input  logic              csn_i,
   input  logic              sdi_i,
   input  logic              rstn_i,
   input  logic              shdnn_i,
   output logic [CODE_W-1:0] wiper_code_o,
   output logic [TAPS-1:0]   tap_sel_o,
   output logic              a_open_o,
   output logic              w_short_b_o,
   output logic              sdo_pulldown_o
);
   localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(midscale(CODE_W));

   if (CODE_W < 2 || CODE_W > 10) begin : g_bad_code_w
      $error("wiper_code_ctrl: CODE_W out of range 2..10");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("wiper_code_ctrl: SYNC_STAGES must be at least 2");
   end

   logic      rst_n;
   wcr_pins_t pin_raw, pin_s;
   logic      sclk_d_q, csn_d_q;
   logic      shift_pulse, xfer_pulse, sd_active;
   logic [CODE_W-1:0] sr_word;
   logic              sr_tail;

   wcr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
      .clk_i        (clk_i),
      .rstn_async_i (rstn_i),
      .rstn_o       (rst_n)
   );

   assign pin_raw = '{sclk: sclk_i, csn: csn_i, sdi: sdi_i, shdnn: shdnn_i};

   wcr_sync #(
      .WIDTH   (PIN_CNT),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_IDLE)
   ) u_pin_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .d_i    (pin_raw),
      .q_o    (pin_s)
   );

   // previous-cycle copies for edge detection
   always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d_q <= 1'b0;
         csn_d_q  <= 1'b1;
      end else begin
         sclk_d_q <= pin_s.sclk;
         csn_d_q  <= pin_s.csn;
      end
   end

   assign shift_pulse = pin_s.sclk && !sclk_d_q && !pin_s.csn;
   assign xfer_pulse  = pin_s.csn && !csn_d_q;
   assign sd_active   = !pin_s.shdnn;

   wcr_shift #(.CODE_W(CODE_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk_i   (clk_i),
      .rst_ni  (rst_n),
      .shift_i (shift_pulse),
      .sdi_i   (pin_s.sdi),
      .word_o  (sr_word),
      .tail_o  (sr_tail)
   );

   wcr_latch #(.CODE_W(CODE_W), .RST_CODE(MID_CODE)) u_latch (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .load_i (xfer_pulse),
      .din_i  (sr_word),
      .code_o (wiper_code_o)
   );

   wcr_tap_decode #(.CODE_W(CODE_W)) u_decode (
      .clk_i    (clk_i),
      .rst_ni   (rst_n),
      .code_i   (wiper_code_o),
      .park_b_i (sd_active),
      .tap_o    (tap_sel_o)
   );

   assign a_open_o       = sd_active;
   assign w_short_b_o    = sd_active;
   // open drain: a zero at the tail pulls the line low; shutdown releases it
   assign sdo_pulldown_o = !sd_active && !sr_tail;

   // R7
   sd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      a_open_o |-> (!sdo_pulldown_o && w_short_b_o));
endmodule

// File: tb/wiper_code_ctrl_tb.sv
module wiper_code_ctrl_tb;
   localparam int H = 6;
   localparam logic [6:0] MID = 7'h40;

   logic clk = 1'b0;
   logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0, rstn = 1'b0, shdnn = 1'b1;
   logic [6:0]   code1, code2;
   logic [127:0] tap1, tap2;
   logic a_open1, wb1, pd1, a_open2, wb2, pd2;
   int total = 0, bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wiper_code_ctrl u_dut (
      .clk_i(clk), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi), .rstn_i(rstn),
      .shdnn_i(shdnn), .wiper_code_o(code1), .tap_sel_o(tap1),
      .a_open_o(a_open1), .w_short_b_o(wb1), .sdo_pulldown_o(pd1));

   // downstream chained device, input pulled up through the open drain line
   wiper_code_ctrl u_dut2 (
      .clk_i(clk), .sclk_i(sclk), .csn_i(csn), .sdi_i(~pd1), .rstn_i(rstn),
      .shdnn_i(shdnn), .wiper_code_o(code2), .tap_sel_o(tap2),
      .a_open_o(a_open2), .w_short_b_o(wb2), .sdo_pulldown_o(pd2));

   task automatic chk(input bit ok, input string req,
                      input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_h();
      repeat (H) @(negedge clk);
   endtask

   // sends n bits of val, first bit = val[n-1]; optionally checks the line
   task automatic send_bits(input logic [31:0] val, input int n, input bit close,
                            input bit chk_sdo, input logic [6:0] prev);
      @(negedge clk);
      csn = 1'b0; sclk = 1'b0;
      wait_h();
      for (int i = n - 1; i >= 0; i--) begin
         int k;
         k = n - 1 - i;
         sdi = val[i];
         wait_h();
         if (chk_sdo && k < 7)
            chk((~pd1) == prev[6-k], "R4 line before shift", 128'(~pd1), 128'(prev[6-k]));
         sclk = 1'b1;
         wait_h();
         sclk = 1'b0;
      end
      wait_h();
      if (close) begin
         csn = 1'b1;
         wait_h(); wait_h();
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [6:0] prev;
      repeat (5) @(negedge clk);
      rstn = 1'b1;
      repeat (10) @(negedge clk);

      // R5 reset state
      chk(code1 == MID, "R5 reset code", 128'(code1), 128'(MID));
      chk(pd1 == 1'b1, "R5 cleared shift stage pulls low", 128'(pd1), 128'd1);
      chk(tap1 == (128'd1 << 64), "R10 midscale tap", tap1, 128'd1 << 64);
      chk(a_open1 == 1'b0 && wb1 == 1'b0, "R7 not in shutdown", 128'({a_open1, wb1}), 128'd0);

      // R1 R2 R10 R4: sweep of every code
      prev = 7'h00;
      for (int c = 0; c < 128; c++) begin
         send_bits(32'(c), 7, 1'b1, 1'b1, prev);
         chk(code1 == 7'(c), "R1 R2 code after frame", 128'(code1), 128'(c));
         chk(tap1 == (128'd1 << c), "R10 one-hot tap", tap1, 128'd1 << c);
         prev = 7'(c);
      end

      // R2 over-long frame: low 7 bits win
      send_bits(32'b101_1100110, 10, 1'b1, 1'b0, 7'h0);
      chk(code1 == 7'b1100110, "R2 10-bit frame", 128'(code1), 128'(7'b1100110));

      // R3 serial activity with select high
      begin
         logic line0;
         line0 = ~pd1;
         for (int j = 0; j < 6; j++) begin
            sdi = j[0]; wait_h(); sclk = 1'b1; wait_h(); sclk = 1'b0;
         end
         wait_h();
         chk(code1 == 7'b1100110, "R3 code unchanged", 128'(code1), 128'(7'b1100110));
         chk((~pd1) == line0, "R3 line unchanged", 128'(~pd1), 128'(line0));
      end

      // R4 daisy chain, 14-bit frame
      send_bits({18'd0, 7'h5A, 7'h23}, 14, 1'b1, 1'b0, 7'h0);
      chk(code1 == 7'h23, "R4 upstream gets last bits", 128'(code1), 128'(7'h23));
      chk(code2 == 7'h5A, "R4 downstream gets first bits", 128'(code2), 128'(7'h5A));

      // R5 reset during shifting
      send_bits(32'b1011, 4, 1'b0, 1'b0, 7'h0);
      @(negedge clk); rstn = 1'b0;
      wait_h();
      chk(code1 == MID, "R5 reset mid-frame", 128'(code1), 128'(MID));
      chk(pd1 == 1'b1, "R5 shift stage cleared", 128'(pd1), 128'd1);
      csn = 1'b1; wait_h();
      rstn = 1'b1; wait_h(); wait_h();
      chk(code1 == MID, "R5 midscale after release", 128'(code1), 128'(MID));

      // R5 reset pulse with select high
      send_bits(32'h11, 7, 1'b1, 1'b0, 7'h0);
      chk(code1 == 7'h11, "R2 load before reset", 128'(code1), 128'(7'h11));
      @(negedge clk); rstn = 1'b0; wait_h(); rstn = 1'b1; wait_h(); wait_h();
      chk(code1 == MID, "R5 reset with select high", 128'(code1), 128'(MID));

      // R6 select release and reset in the same cycle
      send_bits(32'h33, 7, 1'b0, 1'b0, 7'h0);
      @(negedge clk); csn = 1'b1; rstn = 1'b0;
      wait_h(); rstn = 1'b1; wait_h(); wait_h();
      chk(code1 == MID, "R6 reset beats transfer", 128'(code1), 128'(MID));

      // R7 R8 shutdown without load
      send_bits(32'h2A, 7, 1'b1, 1'b0, 7'h0);
      @(negedge clk); shdnn = 1'b0; wait_h();
      chk(a_open1 && wb1, "R7 controls asserted", 128'({a_open1, wb1}), 128'd3);
      chk(pd1 == 1'b0, "R7 pull-down off", 128'(pd1), 128'd0);
      chk(tap1 == 128'd1, "R7 tap parked at B", tap1, 128'd1);
      chk(code1 == 7'h2A, "R8 code kept", 128'(code1), 128'(7'h2A));
      shdnn = 1'b1; wait_h();
      chk(tap1 == (128'd1 << 42), "R8 tap restored", tap1, 128'd1 << 42);

      // R9 load during shutdown
      @(negedge clk); shdnn = 1'b0; wait_h();
      send_bits(32'h15, 7, 1'b1, 1'b0, 7'h0);
      chk(code1 == 7'h15, "R9 code loaded in shutdown", 128'(code1), 128'(7'h15));
      chk(tap1 == 128'd1, "R9 still parked", tap1, 128'd1);
      chk(pd1 == 1'b0, "R7 line released", 128'(pd1), 128'd0);
      shdnn = 1'b1; wait_h();
      chk(tap1 == (128'd1 << 21), "R9 new tap after release", tap1, 128'd1 << 21);
      chk(a_open1 == 1'b0, "R7 A reconnected", 128'(a_open1), 128'd0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule